// File: doc/BRIEF.md
# Dual-Channel Transfer-Word Address Sequencer

This block keeps the register-file addresses for two memory channels. Channel 1 takes a fresh address from a source bus whenever the address-load strobe is active. Channel 2 takes a copy of channel 1 whenever the channel-2 load strobe is active. While a four-word transfer runs, each channel steps the low nibble of its address. A one-hot ring of four bits, one per channel, tracks which word of the transfer is current. The ring gates the step, so the address moves only on the word slot that the ring marks.

The channel-2 load also captures the low nibble of channel 1 into a separate compare nibble. That nibble feeds two things. The first is a registered equality flag against the low nibble of whichever register address is currently selected outside the block. The second is a hold path that rebuilds the channel-2 address from the high nibble of channel 1 and the captured nibble. A 4-bit pattern input stands in for the upstream transfer-control table that seeds ring 1. An active-low run input clears both rings at once, without waiting for a clock edge.

Top module: `xw_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears both addresses, both rings, both request-history flags, the compare nibble and the equality flag to 0 at the next clock edge.
- R2: When `ld_adr` is 1, `adr1` takes `src_adr` and `ring1` takes `ring_pat` at the next edge.
- R3: When `ld_ch2` is 1, at the next edge `adr2` takes the current `adr1`, `ring2` takes the current `ring1`, and the compare nibble takes `adr1[3:0]`. The old values are used even if `ld_adr` is active in the same cycle.
- R4: A ring rotates one place toward its MSB per enabled cycle, with bit 3 wrapping into bit 0 (0001, 0010, 0100, 1000, 0001). `shift1_en` enables ring 1 and `ch2_will_get` enables ring 2. A load in the same cycle takes priority over the rotation. Bit 3 of a ring is its transfer-word flag and bit 0 is its delayed flag.
- R5: A channel's low nibble `adr[3:0]` increments modulo 16 at an edge when that channel's request input (`ch1_needs` or `ch2_will_get`) was 1 at the previous edge and its ring bit 0 is 1. The high nibble `adr[7:4]` never changes on an increment, and 4'hF wraps to 4'h0.
- R6: When a channel's ring bit 0 is 0, its address does not increment, even if the request was present on the previous edge.
- R7: `cmp_eq` is 1 one edge after the compare nibble equals `cur_addr[3:0]`; `cur_addr[7:4]` is ignored. Increments of `adr2` do not change the compare nibble.
- R8: When `hold` is 1 and `ld_ch2` is 0, `adr2` becomes {`adr1[7:4]`, compare nibble} at the next edge. The priority on `adr2` is channel-2 load first, then hold, then increment.
- R9: Driving `run_n` low clears `ring1` and `ring2` immediately, without a clock edge. The addresses are left as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_n | input | 1 | Active-low asynchronous clear of both rings |
| ld_adr | input | 1 | Address-load strobe for channel 1 |
| src_adr | input | 8 | Source bus for the channel-1 address |
| ring_pat | input | 4 | Seed pattern for ring 1 (stands in for the control table) |
| ld_ch2 | input | 1 | Channel-2 load strobe (copy from channel 1, capture compare nibble) |
| shift1_en | input | 1 | Rotate enable for ring 1 |
| ch1_needs | input | 1 | Channel-1 register-file request |
| ch2_will_get | input | 1 | Channel-2 register-file grant; also rotates ring 2 |
| hold | input | 1 | Rebuild channel-2 address from channel-1 high nibble and compare nibble |
| cur_addr | input | 8 | Currently selected register address for the comparator |
| adr1 | output | 8 | Channel-1 address |
| adr2 | output | 8 | Channel-2 address |
| ring1 | output | 4 | Channel-1 word ring |
| ring2 | output | 4 | Channel-2 word ring |
| cmp_eq | output | 1 | Registered compare-nibble equality flag |

## Verification
The embedded assertions check these behaviours on every cycle:
- ring loading and rotation;
- the increment rule and its inhibit when bit 0 of the ring is 0;
- the high nibble staying fixed;
- the compare nibble staying stable between captures;
- the form of the hold reload.

Only the bench scenarios can show the following:
- the nibble rollover from F to 0;
- the one-cycle lag between a request and the increment it allows;
- the priority when a channel-2 load, a channel-1 load and a hold coincide;
- the comparator ignoring the high nibble;
- the run clear acting between clock edges.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int ADDR_W_DEF = 8;
  localparam int NIB_W_DEF  = 4;
  localparam int RING_W_DEF = 4;

  // next-value source for a channel address register
  typedef enum logic [1:0] {
    NXT_KEEP = 2'd0,
    NXT_LOAD = 2'd1,
    NXT_HOLD = 2'd2,
    NXT_INC  = 2'd3
  } adr_nxt_e;
endpackage

// File: rtl/xw_ring.sv
module xw_ring #(
  parameter int W = xw_pkg::RING_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n)     q <= '0;
    else if (rst)   q <= '0;
    else if (ld)    q <= ld_val;
    else if (shift) q <= {q[W-2:0], q[W-1]};
  end

  assert_ring_load_R2_R3: assert property (@(posedge clk) disable iff (rst || !run_n)
    ld |=> q == $past(ld_val));

  assert_ring_rotate_R4: assert property (@(posedge clk) disable iff (rst || !run_n)
    (shift && !ld) |=> (q[0] == $past(q[W-1])) && (q[W-1:1] == $past(q[W-2:0])));
endmodule

// File: rtl/xw_chan_addr.sv
module xw_chan_addr
  import xw_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int NIB_W  = NIB_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              hold,
  input  logic [ADDR_W-1:0] hold_val,
  input  logic              req,
  input  logic              dly,
  output logic [ADDR_W-1:0] adr
);
  localparam int HI_W = ADDR_W - NIB_W;

  logic     held;
  adr_nxt_e nxt;
  logic [NIB_W-1:0] lo_inc;

  always_ff @(posedge clk) begin
    if (rst) held <= 1'b0;
    else     held <= req;
  end

  always_comb begin
    if (ld)               nxt = NXT_LOAD;
    else if (hold)        nxt = NXT_HOLD;
    else if (held && dly) nxt = NXT_INC;
    else                  nxt = NXT_KEEP;
  end

  assign lo_inc = adr[NIB_W-1:0] + NIB_W'(1);

  always_ff @(posedge clk) begin
    if (rst) adr <= '0;
    else begin
      unique case (nxt)
        NXT_LOAD: adr <= ld_val;
        NXT_HOLD: adr <= hold_val;
        NXT_INC:  adr <= {adr[ADDR_W-1:NIB_W], lo_inc};
        default:  adr <= adr;
      endcase
    end
  end

  assert_hi_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (!ld && !hold) |=> adr[ADDR_W-1:NIB_W] == $past(adr[ADDR_W-1:NIB_W]));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(req) && dly && !ld && !hold) |=> adr[NIB_W-1:0] == NIB_W'($past(adr[NIB_W-1:0]) + NIB_W'(1)));

  assert_no_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!dly && !ld && !hold) |=> $stable(adr));

  assert_load_R2_R3: assert property (@(posedge clk) disable iff (rst)
    ld |=> adr == $past(ld_val));

  initial assert (HI_W > 0) else $error("address must be wider than its stepped field");
endmodule

// File: rtl/xw_cmp.sv
module xw_cmp #(
  parameter int NIB_W = xw_pkg::NIB_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [NIB_W-1:0] cap_val,
  input  logic [NIB_W-1:0] probe,
  output logic [NIB_W-1:0] nib,
  output logic             eq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nib <= '0;
      eq  <= 1'b0;
    end else begin
      if (cap) nib <= cap_val;
      eq <= (nib == probe);
    end
  end

  assert_nib_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(nib));

  assert_nib_capture_R3: assert property (@(posedge clk) disable iff (rst)
    cap |=> nib == $past(cap_val));
endmodule

// File: rtl/xw_addr_seq.sv
module xw_addr_seq #(
  parameter int ADDR_W = xw_pkg::ADDR_W_DEF,
  parameter int NIB_W  = xw_pkg::NIB_W_DEF,
  parameter int RING_W = xw_pkg::RING_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_n,
  input  logic              ld_adr,
  input  logic [ADDR_W-1:0] src_adr,
  input  logic [RING_W-1:0] ring_pat,
  input  logic              ld_ch2,
  input  logic              shift1_en,
  input  logic              ch1_needs,
  input  logic              ch2_will_get,
  input  logic              hold,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] adr1,
  output logic [ADDR_W-1:0] adr2,
  output logic [RING_W-1:0] ring1,
  output logic [RING_W-1:0] ring2,
  output logic              cmp_eq
);
  localparam int HI_W = ADDR_W - NIB_W;

  logic [NIB_W-1:0]  cmp_nib;
  logic [ADDR_W-1:0] hold_val;

  assign hold_val = {adr1[ADDR_W-1:NIB_W], cmp_nib};

  xw_ring #(.W(RING_W)) u_ring1 (
    .clk(clk), .rst(rst), .run_n(run_n),
    .ld(ld_adr), .ld_val(ring_pat), .shift(shift1_en), .q(ring1)
  );

  xw_ring #(.W(RING_W)) u_ring2 (
    .clk(clk), .rst(rst), .run_n(run_n),
    .ld(ld_ch2), .ld_val(ring1), .shift(ch2_will_get), .q(ring2)
  );

  xw_chan_addr #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_adr1 (
    .clk(clk), .rst(rst),
    .ld(ld_adr), .ld_val(src_adr),
    .hold(1'b0), .hold_val(src_adr),
    .req(ch1_needs), .dly(ring1[0]),
    .adr(adr1)
  );

  xw_chan_addr #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_adr2 (
    .clk(clk), .rst(rst),
    .ld(ld_ch2), .ld_val(adr1),
    .hold(hold), .hold_val(hold_val),
    .req(ch2_will_get), .dly(ring2[0]),
    .adr(adr2)
  );

  xw_cmp #(.NIB_W(NIB_W)) u_cmp (
    .clk(clk), .rst(rst),
    .cap(ld_ch2), .cap_val(adr1[NIB_W-1:0]),
    .probe(cur_addr[NIB_W-1:0]),
    .nib(cmp_nib), .eq(cmp_eq)
  );

  assert_hold_form_R8: assert property (@(posedge clk) disable iff (rst)
    (hold && !ld_ch2) |=> (adr2[NIB_W-1:0] == $past(cmp_nib)) &&
                          (adr2[ADDR_W-1:NIB_W] == $past(adr1[ADDR_W-1:NIB_W])));

  assert_ch2_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_ch2 && hold) |=> adr2 == $past(adr1));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (adr1 == '0) && (adr2 == '0) && (ring1 == '0) && (ring2 == '0) && !cmp_eq);

  initial assert (HI_W > 0 && RING_W > 1) else $error("bad parameter set");
endmodule

// File: tb/test_xw_addr_seq.sv
module test_xw_addr_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_n = 1'b1;
  logic       ld_adr = 1'b0;
  logic [7:0] src_adr = '0;
  logic [3:0] ring_pat = '0;
  logic       ld_ch2 = 1'b0;
  logic       shift1_en = 1'b0;
  logic       ch1_needs = 1'b0;
  logic       ch2_will_get = 1'b0;
  logic       hold = 1'b0;
  logic [7:0] cur_addr = '0;
  logic [7:0] adr1, adr2;
  logic [3:0] ring1, ring2;
  logic       cmp_eq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  xw_addr_seq i_xw_addr_seq (
    .clk(clk), .rst(rst), .run_n(run_n), .ld_adr(ld_adr), .src_adr(src_adr),
    .ring_pat(ring_pat), .ld_ch2(ld_ch2), .shift1_en(shift1_en),
    .ch1_needs(ch1_needs), .ch2_will_get(ch2_will_get), .hold(hold),
    .cur_addr(cur_addr), .adr1(adr1), .adr2(adr2), .ring1(ring1),
    .ring2(ring2), .cmp_eq(cmp_eq)
  );

  typedef struct packed {
    logic       la;
    logic [7:0] src;
    logic [3:0] pat;
    logic       l2;
    logic       sh;
    logic       nd;
    logic       wg;
    logic       hd;
    logic [7:0] ea1;
    logic [7:0] ea2;
    logic [3:0] er1;
    logic [3:0] er2;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1, 8'h3E, 4'b0001, 0,0,0,0,0, 8'h3E, 8'h00, 4'b0001, 4'b0000}, // R2 load
    '{0, 8'h00, 4'b0000, 1,0,1,0,0, 8'h3E, 8'h3E, 4'b0001, 4'b0001}, // R3 copy, no step yet
    '{0, 8'h00, 4'b0000, 0,0,1,0,0, 8'h3F, 8'h3E, 4'b0001, 4'b0001}, // R5 step
    '{0, 8'h00, 4'b0000, 0,0,1,0,0, 8'h30, 8'h3E, 4'b0001, 4'b0001}, // R5 wrap F->0
    '{0, 8'h00, 4'b0000, 0,1,0,0,0, 8'h31, 8'h3E, 4'b0010, 4'b0001}, // R5 lagged step, R4 rotate
    '{0, 8'h00, 4'b0000, 0,0,1,0,0, 8'h31, 8'h3E, 4'b0010, 4'b0001}, // R5 no history yet
    '{0, 8'h00, 4'b0000, 0,0,1,0,0, 8'h31, 8'h3E, 4'b0010, 4'b0001}, // R6 inhibit
    '{0, 8'h00, 4'b0000, 0,1,1,0,0, 8'h31, 8'h3E, 4'b0100, 4'b0001}, // R6/R4
    '{0, 8'h00, 4'b0000, 0,1,1,0,0, 8'h31, 8'h3E, 4'b1000, 4'b0001}, // R4
    '{0, 8'h00, 4'b0000, 0,1,0,0,0, 8'h31, 8'h3E, 4'b0001, 4'b0001}, // R4 wrap
    '{0, 8'h00, 4'b0000, 0,0,0,1,0, 8'h31, 8'h3E, 4'b0001, 4'b0010}, // R4 ring2
    '{0, 8'h00, 4'b0000, 0,0,0,0,0, 8'h31, 8'h3E, 4'b0001, 4'b0010}, // R6 ring2 bit0 clear
    '{0, 8'h00, 4'b0000, 0,0,0,1,0, 8'h31, 8'h3E, 4'b0001, 4'b0100}, // R4
    '{0, 8'h00, 4'b0000, 0,0,0,1,0, 8'h31, 8'h3E, 4'b0001, 4'b1000}, // R4
    '{0, 8'h00, 4'b0000, 0,0,0,1,0, 8'h31, 8'h3E, 4'b0001, 4'b0001}, // R4
    '{0, 8'h00, 4'b0000, 0,0,0,0,0, 8'h31, 8'h3F, 4'b0001, 4'b0001}, // R5 ch2 step
    '{0, 8'h00, 4'b0000, 0,0,0,0,1, 8'h31, 8'h3E, 4'b0001, 4'b0001}, // R8 hold, R7 nib kept
    '{1, 8'hA5, 4'b1000, 1,0,0,0,0, 8'hA5, 8'h31, 4'b1000, 4'b0001}, // R3 old adr1 used
    '{0, 8'h00, 4'b0000, 0,0,0,0,1, 8'hA5, 8'hA1, 4'b1000, 4'b0001}, // R8 high from ch1
    '{0, 8'h00, 4'b0000, 1,0,0,0,1, 8'hA5, 8'hA5, 4'b1000, 4'b1000}  // R8 load beats hold
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 adr1", adr1, 8'h00);
    check("R1 adr2", adr2, 8'h00);
    check("R1 rings", {ring1, ring2}, 8'h00);
    check("R1 cmp_eq", cmp_eq, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ld_adr = VEC[i].la; src_adr = VEC[i].src; ring_pat = VEC[i].pat;
      ld_ch2 = VEC[i].l2; shift1_en = VEC[i].sh; ch1_needs = VEC[i].nd;
      ch2_will_get = VEC[i].wg; hold = VEC[i].hd;
      @(negedge clk);
      check($sformatf("R2-R8 vec%0d", i),
            {adr1, adr2, ring1, ring2},
            {VEC[i].ea1, VEC[i].ea2, VEC[i].er1, VEC[i].er2});
    end
    ld_adr = 0; ld_ch2 = 0; shift1_en = 0; ch1_needs = 0; ch2_will_get = 0; hold = 0;

    // R7: compare nibble is now 5; high nibble of cur_addr ignored
    cur_addr = 8'h05;
    @(negedge clk);
    check("R7 equal", cmp_eq, 1'b1);
    cur_addr = 8'hF5;
    @(negedge clk);
    check("R7 high nibble ignored", cmp_eq, 1'b1);
    cur_addr = 8'h06;
    @(negedge clk);
    check("R7 not equal", cmp_eq, 1'b0);

    // R9: asynchronous ring clear between edges
    #2 run_n = 1'b0;
    #1;
    check("R9 rings cleared", {ring1, ring2}, 8'h00);
    check("R9 addresses kept", {adr1, adr2}, 16'hA5A5);
    #1 run_n = 1'b1;
    @(negedge clk);

    // R1: reset from a busy state
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", {adr1, adr2, ring1, ring2, 7'd0, cmp_eq}, 32'h0);
    rst = 1'b0;
    cur_addr = 8'h10;
    @(negedge clk);
    check("R1 compare nibble cleared", cmp_eq, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule